// File: doc/BRIEF.md
# Core Clock Source Switching Controller

This block produces the processor core clock from one of two sources: a fast clock and a memory clock. The memory clock is made inside the block by dividing the fast clock by two. A small policy engine chooses the source. It takes single-cycle commands that turn switching on or off, and a level input that stays high while a cache line fill is outstanding after a miss. Every change of source passes through a glitch-free handshake. Each source has its own enable flop, and each enable flop is synchronized in its own clock domain. The source being released is gated off in its low phase before the other source is gated on.

While switching is on, the core runs from the fast clock. It drops to the memory clock only for as long as a fill is pending. Turning switching off does not force the slow clock. The core keeps whichever source it had at that moment. If a fill arrives while switching is off, the core moves to the memory clock. It stays there until switching is turned on again.

The block also holds a 5-bit frequency-select value for an external multiplier. The value is stored, range-checked and exported. A write of an unsupported code is dropped, and a sticky error flag is raised.

Top module: `ccs_core_clock_switch`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `fast_clk` edge) clears `sw_enabled`, `src_is_fast`, `fsel_value` (to 00000) and `fsel_error`. After reset the core clock comes from the memory clock.
- R2: The memory clock runs at exactly half the fast clock rate. While it drives `core_clk`, 32 fast-clock periods contain 16 (±1) rising edges of `core_clk`.
- R3: While switching is on and `fill_pending` is low, `core_clk` is driven by the fast clock, giving 32 (±1) rising edges per 32 fast periods.
- R4: While switching is on and `fill_pending` is high, `core_clk` is driven by the memory clock. When `fill_pending` falls, the core returns to the fast clock.
- R5: A pulse on `sw_disable_cmd` clears `sw_enabled` and leaves the core on the source it was using. With no fill pending, that source does not change.
- R6: While switching is off, a high `fill_pending` moves the core to the memory clock. The core stays there after the fill ends, until a pulse on `sw_enable_cmd`.
- R7: A pulse on `sw_enable_cmd` sets `sw_enabled` one cycle later. When the enable and disable pulses arrive in the same cycle, the disable takes effect.
- R8: A write (`fsel_wr` high) with `fsel_wdata` in 0..11 is stored in `fsel_value` on the next cycle and clears `fsel_error`.
- R9: A write with `fsel_wdata` in 12..31 leaves `fsel_value` unchanged and sets `fsel_error`. The flag stays set until the next in-range write.
- R10: At most one source is gated onto `core_clk` at any time. No high or low phase of `core_clk` is shorter than half a fast-clock period.
- R11: `src_is_fast` (1 = fast clock, 0 = memory clock) changes only after the new source's enable has been seen in the fast domain and the old source's enable has been seen released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast source clock; all control logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sw_enable_cmd | input | 1 | One-cycle pulse that turns source switching on |
| sw_disable_cmd | input | 1 | One-cycle pulse that turns source switching off |
| fill_pending | input | 1 | High while a cache fill after a miss is outstanding |
| fsel_wr | input | 1 | Write strobe for the frequency-select value |
| fsel_wdata | input | 5 | Frequency-select code to write |
| core_clk | output | 1 | Glitch-free core clock |
| src_is_fast | output | 1 | Settled source status: 1 fast clock, 0 memory clock |
| sw_enabled | output | 1 | Switching enable status |
| fsel_value | output | 5 | Stored frequency-select code |
| fsel_error | output | 1 | Sticky flag set by an unsupported code write |

## Verification
The hardest situation to reach is a reversal of the requested source while a handshake is still running. In that case one enable pipeline is part-filled while the other side is draining, and only the cross-coupled busy terms keep the two gates apart. Random runs of enable, disable and short fill pulses are applied back to back with no settling time between them, so requests flip faster than the synchronizers can finish. The width of every `core_clk` phase is timed throughout. After each burst, the inputs are held quiet and the settled source is compared with a model built from the requirements, using both the status bit and a count of clock edges.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
  localparam int CCS_FSEL_W       = 5;
  localparam int CCS_FSEL_MAX     = 11;
  localparam int CCS_SYNC_STAGES  = 2;
  localparam int CCS_MEM_RST_HOLD = 4;

  typedef enum logic {
    SRC_MEM  = 1'b0,
    SRC_FAST = 1'b1
  } ccs_src_e;
endpackage

// File: rtl/ccs_sync.sv
`timescale 1ns/1ps
module ccs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic busy
);
  logic [STAGES-1:0] sr;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[g] <= 1'b0;
        else     sr[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[g] <= 1'b0;
        else     sr[g] <= sr[g-1];
      end
    end
  end

  assign q    = sr[STAGES-1];
  assign busy = |sr;
endmodule

// File: rtl/ccs_policy.sv
`timescale 1ns/1ps
module ccs_policy (
  input  logic clk,
  input  logic rst,
  input  logic en_cmd,
  input  logic dis_cmd,
  input  logic fill,
  output logic sw_en,
  output logic want_fast
);
  logic sw_en_n;
  logic want_fast_n;

  always_comb begin
    sw_en_n = sw_en;
    if (dis_cmd)     sw_en_n = 1'b0;
    else if (en_cmd) sw_en_n = 1'b1;

    want_fast_n = want_fast;
    if (sw_en_n)   want_fast_n = ~fill;
    else if (fill) want_fast_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en     <= 1'b0;
      want_fast <= 1'b0;
    end else begin
      sw_en     <= sw_en_n;
      want_fast <= want_fast_n;
    end
  end

  AST_ENABLED_RUNS_FAST: assert property (@(posedge clk) disable iff (rst)
    (sw_en && !dis_cmd && !fill) |=> want_fast); // R3
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && !en_cmd && !fill) |=> $stable(want_fast)); // R5
  AST_FILL_PICKS_MEM: assert property (@(posedge clk) disable iff (rst)
    fill |=> !want_fast); // R6
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
    (en_cmd && dis_cmd) |=> !sw_en); // R7
endmodule

// File: rtl/ccs_fsel_reg.sv
`timescale 1ns/1ps
module ccs_fsel_reg #(
  parameter int W   = 5,
  parameter int MAX = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         err
);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  logic code_ok;
  assign code_ok = (wdata <= MAX_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      err   <= 1'b0;
    end else if (wr) begin
      if (code_ok) begin
        value <= wdata;
        err   <= 1'b0;
      end else begin
        err   <= 1'b1;
      end
    end
  end

  AST_GOOD_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata <= MAX_V) |=> (value == $past(wdata) && !err)); // R8
  AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata > MAX_V) |=> ($stable(value) && err)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !wr) |=> err); // R9
endmodule

// File: rtl/ccs_gf_mux.sv
`timescale 1ns/1ps
module ccs_gf_mux #(
  parameter int STAGES   = 2,
  parameter int RST_HOLD = 4
) (
  input  logic fast_clk,
  input  logic rst,
  input  logic want_fast,
  output logic core_clk,
  output logic fast_on_f,
  output logic mem_on_f
);
  localparam int CW = $clog2(RST_HOLD + 1);

  logic          mem_clk;
  logic [CW-1:0] hold_cnt;
  logic          mem_rst;

  always_ff @(posedge fast_clk) begin
    if (rst) mem_clk <= 1'b0;
    else     mem_clk <= ~mem_clk;
  end

  always_ff @(posedge fast_clk) begin
    if (rst) begin
      hold_cnt <= CW'(RST_HOLD);
      mem_rst  <= 1'b1;
    end else begin
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      mem_rst <= (hold_cnt != '0);
    end
  end

  logic f_sy, f_busy, f_en;
  logic m_sy, m_busy, m_en;
  logic f_req, m_req;

  assign f_req = want_fast & ~(m_busy | m_en);
  assign m_req = ~want_fast & ~(f_busy | f_en);

  ccs_sync #(.STAGES(STAGES)) u_fast_sel (
    .clk(fast_clk), .rst(rst), .d(f_req), .q(f_sy), .busy(f_busy)
  );

  always_ff @(negedge fast_clk) begin
    if (rst) f_en <= 1'b0;
    else     f_en <= f_sy;
  end

  ccs_sync #(.STAGES(STAGES)) u_mem_sel (
    .clk(mem_clk), .rst(mem_rst), .d(m_req), .q(m_sy), .busy(m_busy)
  );

  always_ff @(negedge mem_clk) begin
    if (mem_rst) m_en <= 1'b0;
    else         m_en <= m_sy;
  end

  assign core_clk = (fast_clk & f_en) | (mem_clk & m_en);

  ccs_sync #(.STAGES(STAGES)) u_fast_stat (
    .clk(fast_clk), .rst(rst), .d(f_en), .q(fast_on_f), .busy()
  );
  ccs_sync #(.STAGES(STAGES)) u_mem_stat (
    .clk(fast_clk), .rst(rst), .d(m_en), .q(mem_on_f), .busy()
  );

  AST_ONE_SOURCE: assert property (@(posedge fast_clk) disable iff (rst)
    !(f_en && m_en)); // R10
  AST_FAST_WAITS_MEM_IDLE: assert property (@(posedge fast_clk) disable iff (rst)
    $rose(f_busy) |-> $past(!m_en)); // R10
endmodule

// File: rtl/ccs_core_clock_switch.sv
`timescale 1ns/1ps
module ccs_core_clock_switch
  import ccs_pkg::*;
#(
  parameter int FSEL_W      = CCS_FSEL_W,
  parameter int FSEL_MAX    = CCS_FSEL_MAX,
  parameter int SYNC_STAGES = CCS_SYNC_STAGES,
  parameter int MEM_HOLD    = CCS_MEM_RST_HOLD
) (
  input  logic              fast_clk,
  input  logic              rst,
  input  logic              sw_enable_cmd,
  input  logic              sw_disable_cmd,
  input  logic              fill_pending,
  input  logic              fsel_wr,
  input  logic [FSEL_W-1:0] fsel_wdata,
  output logic              core_clk,
  output logic              src_is_fast,
  output logic              sw_enabled,
  output logic [FSEL_W-1:0] fsel_value,
  output logic              fsel_error
);
  logic     want_fast;
  logic     fast_on, mem_on;
  ccs_src_e src_q;

  ccs_policy u_policy (
    .clk(fast_clk), .rst(rst), .en_cmd(sw_enable_cmd), .dis_cmd(sw_disable_cmd),
    .fill(fill_pending), .sw_en(sw_enabled), .want_fast(want_fast)
  );

  ccs_fsel_reg #(.W(FSEL_W), .MAX(FSEL_MAX)) u_fsel (
    .clk(fast_clk), .rst(rst), .wr(fsel_wr), .wdata(fsel_wdata),
    .value(fsel_value), .err(fsel_error)
  );

  ccs_gf_mux #(.STAGES(SYNC_STAGES), .RST_HOLD(MEM_HOLD)) u_mux (
    .fast_clk(fast_clk), .rst(rst), .want_fast(want_fast),
    .core_clk(core_clk), .fast_on_f(fast_on), .mem_on_f(mem_on)
  );

  always_ff @(posedge fast_clk) begin
    if (rst)                    src_q <= SRC_MEM;
    else if (fast_on && !mem_on) src_q <= SRC_FAST;
    else if (mem_on && !fast_on) src_q <= SRC_MEM;
  end

  assign src_is_fast = (src_q == SRC_FAST);

  AST_SRC_FAST_SETTLED: assert property (@(posedge fast_clk) disable iff (rst)
    $rose(src_is_fast) |-> $past(fast_on && !mem_on)); // R11
  AST_SRC_MEM_SETTLED: assert property (@(posedge fast_clk) disable iff (rst)
    $fell(src_is_fast) |-> $past(mem_on && !fast_on)); // R11
endmodule

// File: tb/test_ccs_core_clock_switch.sv
`timescale 1ns/1ps
module test_ccs_core_clock_switch;
  localparam real CLK_PERIOD = 10.0;
  localparam int  WIN = 32;
  localparam int  SETTLE = 24;

  logic       fast_clk = 1'b0;
  logic       rst = 1'b1;
  logic       sw_enable_cmd = 1'b0, sw_disable_cmd = 1'b0, fill_pending = 1'b0;
  logic       fsel_wr = 1'b0;
  logic [4:0] fsel_wdata = '0;
  logic       core_clk, src_is_fast, sw_enabled, fsel_error;
  logic [4:0] fsel_value;

  ccs_core_clock_switch i_ccs_core_clock_switch (
    .fast_clk(fast_clk), .rst(rst), .sw_enable_cmd(sw_enable_cmd),
    .sw_disable_cmd(sw_disable_cmd), .fill_pending(fill_pending),
    .fsel_wr(fsel_wr), .fsel_wdata(fsel_wdata), .core_clk(core_clk),
    .src_is_fast(src_is_fast), .sw_enabled(sw_enabled),
    .fsel_value(fsel_value), .fsel_error(fsel_error)
  );

  always #(CLK_PERIOD / 2.0) fast_clk = ~fast_clk;

  int  checks = 0, errors = 0;
  bit  finished = 0;
  bit  m_sw = 0, m_fast = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  int     edge_cnt = 0;
  int     phase_viol = 0;
  realtime last_t = 0.0;
  bit     seen_edge = 0;

  always @(posedge core_clk) edge_cnt++;
  always @(core_clk) begin
    if (!rst && seen_edge && ($realtime - last_t) < (CLK_PERIOD / 2.0 - 0.001))
      phase_viol++;
    seen_edge = 1;
    last_t = $realtime;
  end

  string tq[$];
  bit    fq[$];
  bit    sq[$];
  bit    mon_busy = 0;

  initial begin
    forever begin
      string t; bit ef; bit es; int c0; int n;
      wait (tq.size() > 0);
      mon_busy = 1;
      t = tq.pop_front(); ef = fq.pop_front(); es = sq.pop_front();
      @(negedge fast_clk);
      check(src_is_fast == ef, {"R11 src status ", t}, src_is_fast, ef);
      check(sw_enabled == es, {"R7 sw status ", t}, sw_enabled, es);
      c0 = edge_cnt;
      repeat (WIN) @(negedge fast_clk);
      n = edge_cnt - c0;
      if (ef) check(n >= WIN - 1 && n <= WIN + 1, {"R3 fast edge count ", t}, n, WIN);
      else    check(n >= WIN/2 - 1 && n <= WIN/2 + 1, {"R2 mem edge count ", t}, n, WIN/2);
      mon_busy = 0;
    end
  end

  task automatic expect_state(input string tag);
    tq.push_back(tag); fq.push_back(m_fast); sq.push_back(m_sw);
    wait (tq.size() == 0);
    wait (!mon_busy);
  endtask

  task automatic drv(input bit en, input bit dis, input bit fill);
    bit sw_n;
    @(negedge fast_clk);
    sw_enable_cmd = en; sw_disable_cmd = dis; fill_pending = fill;
    sw_n = dis ? 1'b0 : (en ? 1'b1 : m_sw);
    if (sw_n)      m_fast = !fill;
    else if (fill) m_fast = 1'b0;
    m_sw = sw_n;
  endtask

  task automatic idle(input int n, input bit fill);
    for (int i = 0; i < n; i++) drv(0, 0, fill);
  endtask

  task automatic fwrite(input logic [4:0] d);
    @(negedge fast_clk);
    fsel_wr = 1'b1; fsel_wdata = d;
    @(negedge fast_clk);
    fsel_wr = 1'b0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge fast_clk);
    rst = 1'b0;
    @(negedge fast_clk);
    // R1 reset state
    check(sw_enabled == 1'b0, "R1 sw_enabled", sw_enabled, 0);
    check(src_is_fast == 1'b0, "R1 src_is_fast", src_is_fast, 0);
    check(fsel_value == 5'd0, "R1 fsel_value", fsel_value, 0);
    check(fsel_error == 1'b0, "R1 fsel_error", fsel_error, 0);

    idle(SETTLE, 0); expect_state("R2 after reset");
    drv(1, 0, 0); @(negedge fast_clk);
    check(sw_enabled == 1'b1, "R7 enable pulse", sw_enabled, 1);
    idle(SETTLE, 0); expect_state("R3 enabled");
    idle(SETTLE, 1); expect_state("R4 fill while enabled");
    idle(SETTLE, 0); expect_state("R4 fill done");
    drv(0, 1, 0); idle(SETTLE, 0); expect_state("R5 disable keeps fast");
    idle(3, 1); idle(SETTLE, 0); expect_state("R6 miss while disabled");
    idle(SETTLE, 0); expect_state("R6 stays on mem");
    drv(1, 0, 0); idle(SETTLE, 0); expect_state("R6 re-enable");
    drv(1, 1, 0); idle(SETTLE, 0); expect_state("R7 both pulses");
    drv(0, 1, 0); drv(0, 0, 1); drv(0, 0, 0); drv(1, 0, 0);
    idle(SETTLE, 0); expect_state("R5 freeze then re-enable");

    // frequency select
    fwrite(5'd7);  @(negedge fast_clk);
    check(fsel_value == 5'd7, "R8 write 7", fsel_value, 7);
    fwrite(5'd11); @(negedge fast_clk);
    check(fsel_value == 5'd11, "R8 write 11", fsel_value, 11);
    check(fsel_error == 1'b0, "R8 err clear", fsel_error, 0);
    fwrite(5'd12); @(negedge fast_clk);
    check(fsel_value == 5'd11, "R9 write 12 ignored", fsel_value, 11);
    check(fsel_error == 1'b1, "R9 err set", fsel_error, 1);
    fwrite(5'd31); repeat (3) @(negedge fast_clk);
    check(fsel_value == 5'd11, "R9 write 31 ignored", fsel_value, 11);
    check(fsel_error == 1'b1, "R9 err sticky", fsel_error, 1);
    fwrite(5'd0); @(negedge fast_clk);
    check(fsel_value == 5'd0, "R8 write 0", fsel_value, 0);
    check(fsel_error == 1'b0, "R9 err cleared", fsel_error, 0);

    // random bursts with no settling between operations
    for (int b = 0; b < 12; b++) begin
      for (int k = 0; k < 10; k++) begin
        int op;
        op = $urandom_range(0, 5);
        case (op)
          0: drv(1, 0, 0);
          1: drv(0, 1, 0);
          2: idle($urandom_range(1, 6), 1);
          3: idle($urandom_range(1, 4), 0);
          4: drv(1, 1, 0);
          default: begin drv(0, 0, 1); drv(1, 0, 0); end
        endcase
      end
      idle(SETTLE, 0);
      expect_state($sformatf("R4 R6 random burst %0d", b));
    end

    check(phase_viol == 0, "R10 short core_clk phases", phase_viol, 0);
    finish_run();
  end
endmodule